// File: doc/BRIEF.md
# NOR Flash Command Interface Decoder

This block is a clocked model of the command front end of a parallel NOR flash part. It watches bus-write cycles, each a one-cycle strobe carrying an address and a data word. It walks the keyed multi-write sequences that guard every state-changing command. Any write that does not fit the current step of a sequence throws the interface back to plain read mode, and nothing else is reported.

From those sequences the block keeps a current mode: read, auto-select, unlock-bypass or program-pending. When a program command completes, it raises a one-cycle program request to the array controller. The request carries the target address and data. A request aimed at a block whose protect bit is set is dropped, and a sticky error flag is set in its place.

Reads take one cycle. In auto-select mode they return the identification codes or a block's protect state. In every other mode they pass through the array data supplied from outside. The cell array, erase operations and all timing of the array are outside the block. An erase or suspend command code is simply a mismatch that returns the interface to read mode.

Top module: `nor_cmd_decoder`

## Requirements
- R1: During reset and on the first cycle after it, mode is read (code 0), prog_req is 0, prog_err is 0 and rd_data is 0. The mode codes are 0 for read, 1 for auto-select, 2 for unlock-bypass and 3 for program-pending.
- R2: Three writes move the interface to auto-select (mode 1): AAh to 555h, then 55h to 2AAh, then 90h to 555h. It stays in auto-select across any number of reads until another write arrives.
- R3: The same two-write prefix followed by A0h to 555h gives mode 3. The next write of any value is taken as address and data. On the following cycle prog_req is high for exactly one cycle, with prog_addr and prog_data equal to that write, and mode returns to 0.
- R4: The two-write prefix followed by 20h to 555h enters unlock-bypass (mode 2).
- R5: A write whose low data byte is F0h returns the mode to read and clears prog_err. This holds at any address and at any step of a sequence, except the data write of an armed program.
- R6: A write that does not match the expected step of a sequence returns the mode to read, also from auto-select and unlock-bypass.
- R7: Commands are matched only on write address bits 10..0 and data bits 7..0. Other bits do not change the decoded command.
- R8: In auto-select, a read with address bits 1..0 = 00 returns 0020h. A read with 01 returns the device code: 00D0h when BOOT_TOP is 1, 00D1h when it is 0. Reads with 11 return 0000h.
- R9: In auto-select, a read with address bits 1..0 = 10 returns 0001h if block_prot[address bits 15..12] is set, and 0000h otherwise.
- R10: In unlock-bypass, a write of A0h (any address) gives mode 3, and the next write issues a program request as in R3, after which the mode is 2 again. A write of 90h keeps mode 2, and a following write of 00h returns to read.
- R11: A program data write whose address bits 15..12 select a block with its block_prot bit set raises no prog_req, leaves prog_addr and prog_data unchanged and sets prog_err. prog_err then stays set until an R5 write clears it.
- R12: A read strobe loads rd_data on the clock edge where it is sampled. Outside auto-select the loaded value is array_data. Without a read strobe, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus-write word address |
| wr_data | input | DATA_W | Bus-write data |
| rd_en | input | 1 | Bus-read strobe |
| rd_addr | input | ADDR_W | Bus-read word address |
| array_data | input | DATA_W | Array contents at rd_addr, from outside |
| block_prot | input | NUM_BLOCKS | Per-block protect bits |
| rd_data | output | DATA_W | Registered read result |
| mode | output | 2 | Current mode code |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| prog_err | output | 1 | Sticky protected-program error |

## Verification
A wrong sequencer step shows on the mode port one clock after the write that caused it. A lost or spurious arm shows one write later as a missing or extra prog_req. A bad block-index or protection decision shows on prog_req and prog_err in the cycle after the data write. A wrong read-mux selection appears in rd_data in the cycle after the read strobe. Comparing every port on every clock against a behavioural model therefore catches each fault within at most two writes of its cause.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   typedef enum logic [1:0] {
      MODE_READ   = 2'd0,
      MODE_AUTO   = 2'd1,
      MODE_BYPASS = 2'd2,
      MODE_PROG   = 2'd3
   } nfc_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UNLK1 = 3'd1,
      ST_UNLK2 = 3'd2,
      ST_ARMED = 3'd3,
      ST_BRST  = 3'd4
   } nfc_step_e;

   localparam int unsigned CMP_AW = 11;
   localparam int unsigned CMP_DW = 8;

   localparam logic [CMP_AW-1:0] KEY_ADDR_A = 11'h555;
   localparam logic [CMP_AW-1:0] KEY_ADDR_B = 11'h2AA;
   localparam logic [CMP_DW-1:0] KEY_DATA_A = 8'hAA;
   localparam logic [CMP_DW-1:0] KEY_DATA_B = 8'h55;
   localparam logic [CMP_DW-1:0] OP_AUTO    = 8'h90;
   localparam logic [CMP_DW-1:0] OP_PROG    = 8'hA0;
   localparam logic [CMP_DW-1:0] OP_BYPASS  = 8'h20;
   localparam logic [CMP_DW-1:0] OP_RESET   = 8'hF0;
   localparam logic [CMP_DW-1:0] OP_BEXIT   = 8'h00;

   localparam logic [7:0] ID_MAKER   = 8'h20;
   localparam logic [7:0] ID_DEV_TOP = 8'hD0;
   localparam logic [7:0] ID_DEV_BOT = 8'hD1;

endpackage

// File: rtl/nfc_seq.sv
module nfc_seq
   import nfc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output nfc_mode_e         mode_o,
   output nfc_mode_e         base_mode_o,
   output logic              fire_o,
   output logic [ADDR_W-1:0] fire_addr_o,
   output logic [DATA_W-1:0] fire_data_o,
   output logic              clr_err_o
);

   if (ADDR_W < CMP_AW) begin : g_chk_aw
      $error("nfc_seq: ADDR_W must cover the command compare bits");
   end
   if (DATA_W < CMP_DW) begin : g_chk_dw
      $error("nfc_seq: DATA_W must cover the command compare bits");
   end

   nfc_step_e step_q, step_d;
   nfc_mode_e base_q, base_d;
   logic      from_byp_q, from_byp_d;

   logic [CMP_AW-1:0] ca;
   logic [CMP_DW-1:0] cd;
   logic              is_reset;

   assign ca       = wr_addr[CMP_AW-1:0];
   assign cd       = wr_data[CMP_DW-1:0];
   assign is_reset = (cd == OP_RESET);

   always_comb begin
      step_d     = step_q;
      base_d     = base_q;
      from_byp_d = from_byp_q;
      fire_o     = 1'b0;
      clr_err_o  = 1'b0;
      if (wr_en) begin
         if (step_q == ST_ARMED) begin
            fire_o = 1'b1;
            step_d = ST_IDLE;
            base_d = from_byp_q ? MODE_BYPASS : MODE_READ;
         end else if (is_reset) begin
            step_d    = ST_IDLE;
            base_d    = MODE_READ;
            clr_err_o = 1'b1;
         end else begin
            step_d = ST_IDLE;
            base_d = MODE_READ;
            unique case (step_q)
               ST_IDLE: begin
                  if (base_q == MODE_BYPASS) begin
                     if (cd == OP_PROG) begin
                        step_d     = ST_ARMED;
                        base_d     = MODE_BYPASS;
                        from_byp_d = 1'b1;
                     end else if (cd == OP_AUTO) begin
                        step_d = ST_BRST;
                        base_d = MODE_BYPASS;
                     end
                  end else if (ca == KEY_ADDR_A && cd == KEY_DATA_A) begin
                     step_d = ST_UNLK1;
                     base_d = base_q;
                  end
               end
               ST_UNLK1: begin
                  if (ca == KEY_ADDR_B && cd == KEY_DATA_B) begin
                     step_d = ST_UNLK2;
                     base_d = base_q;
                  end
               end
               ST_UNLK2: begin
                  if (ca == KEY_ADDR_A) begin
                     if (cd == OP_AUTO) begin
                        base_d = MODE_AUTO;
                     end else if (cd == OP_PROG) begin
                        step_d     = ST_ARMED;
                        from_byp_d = 1'b0;
                     end else if (cd == OP_BYPASS) begin
                        base_d = MODE_BYPASS;
                     end
                  end
               end
               ST_BRST: begin
                  // OP_BEXIT and any other value both leave bypass
                  base_d = MODE_READ;
               end
               default: begin
                  base_d = MODE_READ;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q     <= ST_IDLE;
         base_q     <= MODE_READ;
         from_byp_q <= 1'b0;
      end else begin
         step_q     <= step_d;
         base_q     <= base_d;
         from_byp_q <= from_byp_d;
      end
   end

   assign mode_o      = (step_q == ST_ARMED) ? MODE_PROG : base_q;
   assign base_mode_o = base_q;
   assign fire_addr_o = wr_addr;
   assign fire_data_o = wr_data;

   // R5: a reset code outside an armed program always lands in read mode
   a_r5_reset_to_read: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_reset && mode_o != MODE_PROG) |=> (mode_o == MODE_READ))
      else $error("R5 reset write did not return to read");

   // R3: an armed program consumes exactly one write
   a_r3_arm_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_o == MODE_PROG) |=> (mode_o != MODE_PROG))
      else $error("R3 program stayed armed after its data write");

   // R6: without a write the mode cannot move
   a_r6_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode_o))
      else $error("R6 mode changed without a write");

endmodule

// File: rtl/nfc_prot_gate.sv
module nfc_prot_gate #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_BLOCKS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire_i,
   input  logic [ADDR_W-1:0]     fire_addr_i,
   input  logic [DATA_W-1:0]     fire_data_i,
   input  logic                  clr_err_i,
   input  logic [NUM_BLOCKS-1:0] block_prot_i,
   output logic                  prog_req_o,
   output logic [ADDR_W-1:0]     prog_addr_o,
   output logic [DATA_W-1:0]     prog_data_o,
   output logic                  prog_err_o
);

   localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

   if ((1 << IDX_W) != NUM_BLOCKS) begin : g_chk_pow2
      $error("nfc_prot_gate: NUM_BLOCKS must be a power of two above one");
   end
   if (IDX_W > ADDR_W) begin : g_chk_idx
      $error("nfc_prot_gate: block index wider than address");
   end

   logic [IDX_W-1:0] blk_idx;
   logic             blk_locked;
   logic             pass;

   assign blk_idx    = fire_addr_i[ADDR_W-1 -: IDX_W];
   assign blk_locked = block_prot_i[blk_idx];
   assign pass       = fire_i && !blk_locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_req_o  <= 1'b0;
         prog_addr_o <= '0;
         prog_data_o <= '0;
         prog_err_o  <= 1'b0;
      end else begin
         prog_req_o <= pass;
         if (pass) begin
            prog_addr_o <= fire_addr_i;
            prog_data_o <= fire_data_i;
         end
         if (clr_err_i) begin
            prog_err_o <= 1'b0;
         end else if (fire_i && blk_locked) begin
            prog_err_o <= 1'b1;
         end
      end
   end

   // R3: a request never lasts more than one cycle
   a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req_o |=> !prog_req_o)
      else $error("R3 program request held for two cycles");

   // R11: the error flag only drops on a clear from the sequencer
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_err_o && !clr_err_i) |=> prog_err_o)
      else $error("R11 error flag dropped without a clear");

   // R11: address and data of the last request hold while no request passes
   a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_req_o |-> ($stable(prog_addr_o) || $past(!rst_n)))
      else $error("R11 program address moved without a request");

endmodule

// File: rtl/nfc_rd_mux.sv
module nfc_rd_mux
   import nfc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_BLOCKS = 16,
   parameter bit          BOOT_TOP   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     rd_addr,
   input  nfc_mode_e             base_mode_i,
   input  logic [DATA_W-1:0]     array_data,
   input  logic [NUM_BLOCKS-1:0] block_prot_i,
   output logic [DATA_W-1:0]     rd_data_o
);

   localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
   localparam int unsigned PAD_W = DATA_W - 8;

   if (ADDR_W < IDX_W + 3) begin : g_chk_aw
      $error("nfc_rd_mux: address too narrow for selector and block index");
   end

   logic [7:0]       dev_code;
   logic [7:0]       id_byte;
   logic [IDX_W-1:0] blk_idx;
   logic             unused_rd_bits;

   if (BOOT_TOP) begin : g_top_boot
      assign dev_code = ID_DEV_TOP;
   end else begin : g_bot_boot
      assign dev_code = ID_DEV_BOT;
   end

   assign blk_idx        = rd_addr[ADDR_W-1 -: IDX_W];
   assign unused_rd_bits = ^rd_addr[ADDR_W-IDX_W-1:2];

   always_comb begin
      unique case (rd_addr[1:0])
         2'b00:   id_byte = ID_MAKER;
         2'b01:   id_byte = dev_code;
         2'b10:   id_byte = {7'd0, block_prot_i[blk_idx]};
         default: id_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_o <= '0;
      end else if (rd_en) begin
         rd_data_o <= (base_mode_i == MODE_AUTO) ? {{PAD_W{1'b0}}, id_byte} : array_data;
      end
   end

   // R12: read data only moves on a read strobe
   a_r12_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data_o))
      else $error("R12 read data changed without a read");

   // R8: identification reads never set bits above the low byte
   a_r8_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && base_mode_i == MODE_AUTO) |=> (rd_data_o[DATA_W-1:8] == '0))
      else $error("R8 upper bits set on an identification read");

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import nfc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_BLOCKS = 16,
   parameter bit          BOOT_TOP   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     rd_addr,
   input  logic [DATA_W-1:0]     array_data,
   input  logic [NUM_BLOCKS-1:0] block_prot,
   output logic [DATA_W-1:0]     rd_data,
   output logic [1:0]            mode,
   output logic                  prog_req,
   output logic [ADDR_W-1:0]     prog_addr,
   output logic [DATA_W-1:0]     prog_data,
   output logic                  prog_err
);

   localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

   if (DATA_W < 16) begin : g_chk_dw
      $error("nor_cmd_decoder: DATA_W must be at least 16");
   end

   nfc_mode_e         cur_mode;
   nfc_mode_e         base_mode;
   logic              fire;
   logic [ADDR_W-1:0] fire_addr;
   logic [DATA_W-1:0] fire_data;
   logic              clr_err;

   nfc_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .mode_o      (cur_mode),
      .base_mode_o (base_mode),
      .fire_o      (fire),
      .fire_addr_o (fire_addr),
      .fire_data_o (fire_data),
      .clr_err_o   (clr_err)
   );

   nfc_prot_gate #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_BLOCKS (NUM_BLOCKS)
   ) i_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire_i       (fire),
      .fire_addr_i  (fire_addr),
      .fire_data_i  (fire_data),
      .clr_err_i    (clr_err),
      .block_prot_i (block_prot),
      .prog_req_o   (prog_req),
      .prog_addr_o  (prog_addr),
      .prog_data_o  (prog_data),
      .prog_err_o   (prog_err)
   );

   nfc_rd_mux #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_BLOCKS (NUM_BLOCKS),
      .BOOT_TOP   (BOOT_TOP)
   ) i_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .rd_addr      (rd_addr),
      .base_mode_i  (base_mode),
      .array_data   (array_data),
      .block_prot_i (block_prot),
      .rd_data_o    (rd_data)
   );

   assign mode = cur_mode;

   // protect bits as seen at the previous edge, for the request check
   logic [NUM_BLOCKS-1:0] prot_prev;
   always_ff @(posedge clk) begin
      prot_prev <= block_prot;
   end

   // R3: a request follows an armed program
   a_r3_req_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> ($past(mode) == MODE_PROG))
      else $error("R3 request without an armed program");

   // R11: no request reaches a block that was protected
   a_r11_no_locked_req: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !prot_prev[prog_addr[ADDR_W-1 -: IDX_W]])
      else $error("R11 request issued to a protected block");

   // R11: request and error never rise together
   a_r11_req_or_err: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !$rose(prog_err))
      else $error("R11 request and new error in the same cycle");

endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int NB = 16;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] array_data;
   logic [NB-1:0] block_prot;
   logic [DW-1:0] rd_data;
   logic [1:0]    mode;
   logic          prog_req;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;
   logic          prog_err;

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";
   bit    done     = 1'b0;

   always #10 clk = ~clk;

   assign array_data = rd_addr ^ 16'hA5C3;

   nor_cmd_decoder #(
      .ADDR_W     (AW),
      .DATA_W     (DW),
      .NUM_BLOCKS (NB),
      .BOOT_TOP   (1'b1)
   ) i_nor_cmd_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .array_data (array_data),
      .block_prot (block_prot),
      .rd_data    (rd_data),
      .mode       (mode),
      .prog_req   (prog_req),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .prog_err   (prog_err)
   );

   // reference model: mode kind, sequence position, flags
   int           m_kind;   // 0 read, 1 auto, 2 bypass
   int           m_pos;    // 0 none, 1 first key, 2 second key, 3 armed, 4 bypass exit
   bit           m_byp_arm;
   bit           m_req;
   bit           m_err;
   logic [AW-1:0] m_pa;
   logic [DW-1:0] m_pd;
   logic [DW-1:0] m_rd;

   function automatic logic [DW-1:0] id_read(logic [AW-1:0] a);
      case (a[1:0])
         2'd0:    return 16'h0020;
         2'd1:    return 16'h00D0;
         2'd2:    return {15'd0, block_prot[a[15:12]]};
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_kind = 0; m_pos = 0; m_byp_arm = 0; m_req = 0; m_err = 0;
         m_pa = '0; m_pd = '0; m_rd = '0;
      end else begin
         int ka;
         int kd;
         m_req = 0;
         if (rd_en) m_rd = (m_kind == 1) ? id_read(rd_addr) : (rd_addr ^ 16'hA5C3);
         if (wr_en) begin
            ka = int'(wr_addr & 16'h07FF);
            kd = int'(wr_data & 16'h00FF);
            if (m_pos == 3) begin
               if (block_prot[wr_addr[15:12]]) m_err = 1;
               else begin m_req = 1; m_pa = wr_addr; m_pd = wr_data; end
               m_pos  = 0;
               m_kind = m_byp_arm ? 2 : 0;
            end else if (kd == 'hF0) begin
               m_pos = 0; m_kind = 0; m_err = 0;
            end else if (m_pos == 0 && m_kind == 2) begin
               if (kd == 'hA0) begin m_pos = 3; m_byp_arm = 1; end
               else if (kd == 'h90) m_pos = 4;
               else m_kind = 0;
            end else if (m_pos == 0) begin
               if (ka == 'h555 && kd == 'hAA) m_pos = 1;
               else m_kind = 0;
            end else if (m_pos == 1) begin
               if (ka == 'h2AA && kd == 'h55) m_pos = 2;
               else begin m_pos = 0; m_kind = 0; end
            end else if (m_pos == 2) begin
               m_pos = 0;
               if (ka == 'h555 && kd == 'h90) m_kind = 1;
               else if (ka == 'h555 && kd == 'hA0) begin m_kind = 0; m_pos = 3; m_byp_arm = 0; end
               else if (ka == 'h555 && kd == 'h20) m_kind = 2;
               else m_kind = 0;
            end else begin
               m_pos = 0; m_kind = 0;
            end
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("mode", 32'(mode), 32'((m_pos == 3) ? 3 : m_kind));
         chk("prog_req", 32'(prog_req), 32'(m_req));
         chk("prog_err", 32'(prog_err), 32'(m_err));
         chk("rd_data", 32'(rd_data), 32'(m_rd));
         chk("prog_addr", 32'(prog_addr), 32'(m_pa));
         chk("prog_data", 32'(prog_data), 32'(m_pd));
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic prefix();
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0055);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL %s watchdog actual=%0d expected<%0d", cur_req, WATCHDOG, WATCHDOG);
      summary();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_en = 1'b0; rd_addr = '0; block_prot = '0;
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      cur_req = "R12";
      rd(16'h1234);
      rd(16'hFFFF);
      repeat (2) @(negedge clk);

      cur_req = "R2";
      prefix();
      wr(16'h0555, 16'h0090);
      rd(16'h0040);
      repeat (2) @(negedge clk);

      cur_req = "R8";
      rd(16'h0000);
      rd(16'h0001);
      rd(16'hF7FD);
      rd(16'h0003);

      cur_req = "R9";
      block_prot = 16'h0024;
      rd(16'h2002);
      rd(16'h3002);
      rd(16'h5FFE);

      cur_req = "R5";
      wr(16'h1234, 16'hABF0);
      rd(16'h0001);

      cur_req = "R3";
      prefix();
      wr(16'h0555, 16'h00A0);
      wr(16'h0678, 16'hBEEF);
      repeat (2) @(negedge clk);

      cur_req = "R7";
      wr(16'hF555, 16'h12AA);
      wr(16'h82AA, 16'hFF55);
      wr(16'h7555, 16'h99A0);
      wr(16'h1ABC, 16'hCAFE);
      prefix();
      wr(16'h0D55, 16'h0090);

      cur_req = "R6";
      wr(16'h0555, 16'h00AA);
      wr(16'h02AB, 16'h0055);
      prefix();
      wr(16'h0555, 16'h0090);
      wr(16'h0000, 16'h0030);
      rd(16'h0000);
      prefix();
      wr(16'h0555, 16'h0080);

      cur_req = "R4";
      prefix();
      wr(16'h0555, 16'h0020);
      rd(16'h0000);

      cur_req = "R10";
      wr(16'h0000, 16'h00A0);
      wr(16'h4000, 16'h1111);
      wr(16'h0123, 16'h00A0);
      wr(16'h0010, 16'h2222);
      wr(16'h0000, 16'h0090);
      wr(16'h0000, 16'h0000);
      prefix();
      wr(16'h0555, 16'h0020);
      wr(16'h0000, 16'h0055);

      cur_req = "R11";
      prefix();
      wr(16'h0555, 16'h00A0);
      wr(16'h5000, 16'h3333);
      wr(16'h0555, 16'h00AA);
      wr(16'h0000, 16'h0011);
      prefix();
      wr(16'h0555, 16'h00A0);
      wr(16'h6000, 16'h4444);

      cur_req = "R5";
      prefix();
      wr(16'h0555, 16'h00F0);
      prefix();
      wr(16'h0555, 16'h00A0);
      wr(16'h2100, 16'h5555);
      wr(16'h0555, 16'h00AA);
      wr(16'h3333, 16'h00F0);

      cur_req = "R1";
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      summary();
   end

endmodule